// File: doc/BRIEF.md
# Unaligned Byte-to-Word Packer with Erase Padding

This block turns a byte stream that begins at any byte address into a sequence of bus-width words ready for a flash programming engine. A job is started by presenting a start byte address and a total byte length. The block then takes bytes one at a time over a valid/ready handshake and places each byte into its lane within a word. Each word is emitted together with its word-aligned address, also over a valid/ready handshake.

Flash cells that are left at their erased value stay unprogrammed. Any lane that no stream byte covers is therefore filled with 0xFF. This applies to the lanes below the start offset in the first word and to the lanes above the last byte in the final word. As soon as a job is accepted, the block reports the number of words the job will produce, minus one, so that a command sequencer can issue that count before any data. The bus width is a parameter (1, 2, 4 or 8 bytes).

Top module: `flash_word_packer`

## Requirements
- R1: One cycle after a non-zero-length job is accepted, `cnt_valid` is 1 and `word_cnt_m1` equals ceil((g + L) / BW) - 1. Here g is the start address modulo BW, L is the length and BW is the bus width in bytes. `cnt_valid` stays 1 until the final word has been taken, and the count equals the number of words emitted minus one.
- R2: The first emitted word carries the start address rounded down to a multiple of BW. Each later word of the same job carries the previous address plus BW.
- R3: Byte k of the stream (k counted from 0) lands in word floor((g + k) / BW), in lane (g + k) mod BW. Lane i occupies data bits [8i+7:8i], so the lowest address sits in the least significant byte.
- R4: In the first word, lanes 0 to g-1 carry 0xFF.
- R5: In the final word, every lane above the one that holds the last stream byte carries 0xFF.
- R6: When g = 0 and L is a multiple of BW, every lane of every word carries a stream byte.
- R7: A word is emitted in the cycle after the byte that fills its top lane is taken, or after the last byte of the job is taken. `out_last` is 1 only on the final word of a job.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_data`, `out_addr` and `out_last` hold their values.
- R9: A job with length 0 raises `err_zero_len` for exactly one cycle, after which `job_ready` is 1 again. Such a job takes no bytes (`in_ready` stays 0), emits no words and leaves `cnt_valid` at 0.
- R10: `job_ready` is 1 only when no job is in progress and no word is waiting at the output. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| job_valid | input | 1 | A job descriptor is presented |
| job_ready | output | 1 | The block can accept a job |
| job_addr | input | ADDR_W | Start byte address |
| job_len | input | LEN_W | Total byte count |
| in_valid | input | 1 | A stream byte is presented |
| in_ready | output | 1 | The block takes the byte this cycle |
| in_byte | input | 8 | Stream byte |
| cnt_valid | output | 1 | `word_cnt_m1` is valid for the current job |
| word_cnt_m1 | output | LEN_W | Words in the job, minus one |
| err_zero_len | output | 1 | One-cycle flag: a zero-length job was rejected |
| out_valid | output | 1 | A packed word is presented |
| out_ready | input | 1 | The consumer takes the word |
| out_addr | output | ADDR_W | Word-aligned address of the word |
| out_data | output | 8*BW | Packed word, lane 0 in the low byte |
| out_last | output | 1 | Final word of the job |

## Verification
The hardest case to reach is the one where a backpressured word is held at the output while the next byte is waiting to be taken. It is hardest when the byte waiting to be taken is the last byte of a job whose final word is partial. There, the stall, the trailing padding and the flush on the last byte all meet. The bench sweeps every start offset against a range of lengths with the bus width at 4. For each job it rotates through different stall patterns on the output and gaps in the input stream, so that stalls fall on first, middle and final words, and the final word is partial in every possible way. Every lane of every word is compared against a value computed from the offset, the length and the byte index.

// File: rtl/pkr_pkg.sv
package pkr_pkg;

    typedef enum logic {
        PK_IDLE = 1'b0,
        PK_RUN  = 1'b1
    } pk_state_e;

    localparam logic [7:0] PK_ERASED = 8'hFF;

    // Width of a lane index; at least one bit so a single-lane bus still has a field.
    function automatic int pk_lane_bits(input int bw);
        return (bw > 1) ? $clog2(bw) : 1;
    endfunction

    // Shift that divides by the bus width (width is a power of two).
    function automatic int pk_word_shift(input int bw);
        return (bw > 1) ? $clog2(bw) : 0;
    endfunction

endpackage

// File: rtl/pkr_job_ctrl.sv
module pkr_job_ctrl
    import pkr_pkg::*;
#(
    parameter int BW     = 4,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    localparam int LANE_W = pk_lane_bits(BW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              job_valid,
    input  logic [ADDR_W-1:0] job_addr,
    input  logic [LEN_W-1:0]  job_len,
    input  logic              out_busy,
    input  logic              take,
    output logic              job_ready,
    output logic              run,
    output logic [LANE_W-1:0] lane,
    output logic [ADDR_W-1:0] word_addr,
    output logic              last_byte,
    output logic              flush,
    output logic [LEN_W-1:0]  word_cnt_m1,
    output logic              err_zero_len
);
    localparam int SHIFT  = pk_word_shift(BW);
    localparam int SPAN_W = LEN_W + 2;
    localparam logic [LANE_W-1:0] TOP_LANE  = LANE_W'(BW - 1);
    localparam logic [ADDR_W-1:0] ADDR_MASK = ~ADDR_W'(BW - 1);

    pk_state_e          state_q;
    logic [LANE_W-1:0]  lane_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [LEN_W-1:0]   remain_q;
    logic [LEN_W-1:0]   cnt_q;
    logic               err_q;

    logic               accept;
    logic [LANE_W-1:0]  start_gap;
    logic [SPAN_W-1:0]  span;
    logic [SPAN_W-1:0]  words_total;

    assign job_ready = (state_q == PK_IDLE) && !out_busy;
    assign accept    = job_valid && job_ready;
    assign start_gap = job_addr[LANE_W-1:0] & TOP_LANE;

    // Lanes spanned = gap + length; round up to whole words.
    always_comb begin
        span        = SPAN_W'(start_gap) + SPAN_W'(job_len) + SPAN_W'(BW - 1);
        words_total = span >> SHIFT;
    end

    assign last_byte = (remain_q == LEN_W'(1));
    assign flush     = take && ((lane_q == TOP_LANE) || last_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PK_IDLE;
            lane_q   <= '0;
            addr_q   <= '0;
            remain_q <= '0;
            cnt_q    <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (accept) begin
                if (job_len == '0) begin
                    err_q <= 1'b1;
                end else begin
                    state_q  <= PK_RUN;
                    lane_q   <= start_gap;
                    addr_q   <= job_addr & ADDR_MASK;
                    remain_q <= job_len;
                    cnt_q    <= LEN_W'(words_total - SPAN_W'(1));
                end
            end else if (take) begin
                remain_q <= remain_q - LEN_W'(1);
                if (flush) begin
                    lane_q <= '0;
                    addr_q <= addr_q + ADDR_W'(BW);
                    if (last_byte) begin
                        state_q <= PK_IDLE;
                    end
                end else begin
                    lane_q <= lane_q + LANE_W'(1);
                end
            end
        end
    end

    assign run          = (state_q == PK_RUN);
    assign lane         = lane_q;
    assign word_addr    = addr_q;
    assign word_cnt_m1  = cnt_q;
    assign err_zero_len = err_q;

endmodule

// File: rtl/pkr_lane_fill.sv
module pkr_lane_fill
    import pkr_pkg::*;
#(
    parameter int BW = 4,
    localparam int LANE_W = pk_lane_bits(BW),
    localparam int DW     = 8 * BW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              flush,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        in_byte,
    output logic [DW-1:0]     word_now
);
    localparam logic [DW-1:0] ALL_ERASED = {BW{PK_ERASED}};

    logic [DW-1:0] acc_q;

    // Each lane takes the incoming byte when selected; otherwise it keeps what it holds.
    for (genvar g = 0; g < BW; g++) begin : g_lane
        assign word_now[g*8 +: 8] = (take && (lane == LANE_W'(g))) ? in_byte : acc_q[g*8 +: 8];
    end

    // The accumulator returns to all-erased after each emitted word, so the
    // lanes below the start offset and above the last byte stay 0xFF.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= ALL_ERASED;
        end else if (take) begin
            acc_q <= flush ? ALL_ERASED : word_now;
        end
    end

endmodule

// File: rtl/pkr_out_reg.sv
module pkr_out_reg #(
    parameter int DW     = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DW-1:0]     load_data,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              load_last,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DW-1:0]     out_data,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_addr  <= '0;
            out_last  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
            out_addr  <= load_addr;
            out_last  <= load_last;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/flash_word_packer.sv
module flash_word_packer
    import pkr_pkg::*;
#(
    parameter int BW     = 4,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    localparam int DW     = 8 * BW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              job_valid,
    output logic              job_ready,
    input  logic [ADDR_W-1:0] job_addr,
    input  logic [LEN_W-1:0]  job_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_byte,
    output logic              cnt_valid,
    output logic [LEN_W-1:0]  word_cnt_m1,
    output logic              err_zero_len,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DW-1:0]     out_data,
    output logic              out_last
);
    localparam int LANE_W = pk_lane_bits(BW);

    logic              run;
    logic              take;
    logic              flush;
    logic              last_byte;
    logic [LANE_W-1:0] lane;
    logic [ADDR_W-1:0] word_addr;
    logic [DW-1:0]     word_now;

    assign in_ready  = run && (!out_valid || out_ready);
    assign take      = in_valid && in_ready;
    assign cnt_valid = run || out_valid;

    pkr_job_ctrl #(
        .BW     (BW),
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .job_valid    (job_valid),
        .job_addr     (job_addr),
        .job_len      (job_len),
        .out_busy     (out_valid),
        .take         (take),
        .job_ready    (job_ready),
        .run          (run),
        .lane         (lane),
        .word_addr    (word_addr),
        .last_byte    (last_byte),
        .flush        (flush),
        .word_cnt_m1  (word_cnt_m1),
        .err_zero_len (err_zero_len)
    );

    pkr_lane_fill #(
        .BW (BW)
    ) u_fill (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .flush    (flush),
        .lane     (lane),
        .in_byte  (in_byte),
        .word_now (word_now)
    );

    pkr_out_reg #(
        .DW     (DW),
        .ADDR_W (ADDR_W)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (flush),
        .load_data (word_now),
        .load_addr (word_addr),
        .load_last (last_byte),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_addr  (out_addr),
        .out_last  (out_last)
    );

endmodule

// File: rtl/pkr_chk.sv
module pkr_chk #(
    parameter int BW     = 4,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    localparam int DW     = 8 * BW
) (
    input logic              clk,
    input logic              rst,
    input logic              job_valid,
    input logic              job_ready,
    input logic [ADDR_W-1:0] job_addr,
    input logic [LEN_W-1:0]  job_len,
    input logic              in_valid,
    input logic              in_ready,
    input logic [7:0]        in_byte,
    input logic              cnt_valid,
    input logic [LEN_W-1:0]  word_cnt_m1,
    input logic              err_zero_len,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic [DW-1:0]     out_data,
    input logic              out_last
);
    logic              have_prev;
    logic [ADDR_W-1:0] prev_addr;
    logic [LEN_W-1:0]  seen;
    logic              out_fire;

    assign out_fire = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev <= 1'b0;
            prev_addr <= '0;
            seen      <= '0;
        end else if (out_fire) begin
            have_prev <= !out_last;
            prev_addr <= out_addr;
            seen      <= out_last ? '0 : seen + LEN_W'(1);
        end
    end

    // R2
    addr_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_addr & ADDR_W'(BW - 1)) == '0));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && have_prev) |-> (out_addr == prev_addr + ADDR_W'(BW)));

    // R1
    count_match_chk: assert property (@(posedge clk) disable iff (rst)
        (out_fire && out_last) |-> (word_cnt_m1 == seen));

    // R8
    stall_block_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr) && $stable(out_last)));

    // R9
    zero_len_err_chk: assert property (@(posedge clk) disable iff (rst)
        err_zero_len |-> $past(job_valid && job_ready && (job_len == '0)));

    // R10
    idle_only_chk: assert property (@(posedge clk) disable iff (rst)
        job_ready |-> (!out_valid && !cnt_valid && !in_ready));

endmodule

bind flash_word_packer pkr_chk #(
    .BW     (BW),
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
) u_pkr_chk (.*);

// File: tb/tb_flash_word_packer.sv
module tb_flash_word_packer;
    localparam int BW = 4;
    localparam int AW = 32;
    localparam int LW = 16;
    localparam int DW = 8 * BW;

    logic          clk = 1'b0;
    logic          rst;
    logic          job_valid;
    logic          job_ready;
    logic [AW-1:0] job_addr;
    logic [LW-1:0] job_len;
    logic          in_valid;
    logic          in_ready;
    logic [7:0]    in_byte;
    logic          cnt_valid;
    logic [LW-1:0] word_cnt_m1;
    logic          err_zero_len;
    logic          out_valid;
    logic          out_ready;
    logic [AW-1:0] out_addr;
    logic [DW-1:0] out_data;
    logic          out_last;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    flash_word_packer #(.BW(BW), .ADDR_W(AW), .LEN_W(LW)) dut (
        .clk (clk), .rst (rst),
        .job_valid (job_valid), .job_ready (job_ready),
        .job_addr (job_addr), .job_len (job_len),
        .in_valid (in_valid), .in_ready (in_ready), .in_byte (in_byte),
        .cnt_valid (cnt_valid), .word_cnt_m1 (word_cnt_m1),
        .err_zero_len (err_zero_len),
        .out_valid (out_valid), .out_ready (out_ready),
        .out_addr (out_addr), .out_data (out_data), .out_last (out_last)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] dbyte(input int seed, input int k);
        return 8'((seed * 29) + (k * 11) + 3);
    endfunction

    task automatic run_job(input int gap, input int len, input int seed, input int mode);
        logic [AW-1:0] base;
        int exp_cnt;
        int k;
        int w;
        int cyc;
        bit held;
        logic [DW-1:0] held_data;
        base = AW'(32'h2000 + seed * 64);
        @(negedge clk);
        job_valid = 1'b1;
        job_addr  = base + AW'(gap);
        job_len   = LW'(len);
        #1;
        chk(job_ready == 1'b1, "R10", "job_ready when idle", job_ready, 1);
        @(posedge clk);
        @(negedge clk);
        job_valid = 1'b0;
        if (len == 0) begin
            chk(err_zero_len == 1'b1, "R9", "error flag", err_zero_len, 1);
            chk(cnt_valid == 1'b0, "R9", "no count", cnt_valid, 0);
            in_valid = 1'b1;
            in_byte  = 8'h5A;
            out_ready = 1'b1;
            #1;
            chk(in_ready == 1'b0, "R9", "no byte taken", in_ready, 0);
            @(posedge clk);
            @(negedge clk);
            chk(err_zero_len == 1'b0, "R9", "flag is one cycle", err_zero_len, 0);
            chk(out_valid == 1'b0, "R9", "no word emitted", out_valid, 0);
            chk(job_ready == 1'b1, "R9", "ready again", job_ready, 1);
            in_valid = 1'b0;
            return;
        end
        exp_cnt = (gap + len + BW - 1) / BW - 1;
        chk(cnt_valid == 1'b1, "R1", "cnt_valid after accept", cnt_valid, 1);
        chk(word_cnt_m1 == LW'(exp_cnt), "R1", "word count minus one", word_cnt_m1, exp_cnt);
        chk(job_ready == 1'b0, "R10", "job_ready while busy", job_ready, 0);
        k = 0;
        w = 0;
        cyc = 0;
        held = 1'b0;
        held_data = '0;
        while (w <= exp_cnt && cyc < 4000) begin
            case (mode)
                0: out_ready = 1'b1;
                1: out_ready = (cyc % 3) != 1;
                default: out_ready = (cyc % 5) < 2;
            endcase
            in_valid = (k < len) && ((mode == 0) || ((cyc % 4) != 2));
            in_byte  = dbyte(seed, k);
            #1;
            if (held) begin
                chk(out_valid == 1'b1 && out_data == held_data, "R8", "word held under stall",
                    out_data, held_data);
            end
            held = out_valid && !out_ready;
            held_data = out_data;
            if (out_valid && !out_ready) begin
                chk(in_ready == 1'b0, "R8", "input blocked under stall", in_ready, 0);
            end
            if (out_valid && out_ready) begin
                chk(out_addr == base + AW'(w * BW), "R2", "word address",
                    out_addr, base + AW'(w * BW));
                chk(out_last == (w == exp_cnt), "R7", "last marker", out_last, (w == exp_cnt));
                for (int l = 0; l < BW; l++) begin
                    int idx;
                    logic [7:0] ev;
                    string tag;
                    idx = w * BW + l - gap;
                    if (idx < 0) begin
                        ev = 8'hFF; tag = "R4";
                    end else if (idx >= len) begin
                        ev = 8'hFF; tag = "R5";
                    end else begin
                        ev = dbyte(seed, idx);
                        tag = (gap == 0 && (len % BW) == 0) ? "R6" : "R3";
                    end
                    chk(out_data[l*8 +: 8] == ev, tag, "lane value", out_data[l*8 +: 8], ev);
                end
                w++;
            end
            if (in_valid && in_ready) k++;
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0;
        chk(k == len, "R7", "all bytes taken", k, len);
        chk(w == exp_cnt + 1, "R1", "words emitted", w, exp_cnt + 1);
        #1;
        chk(cnt_valid == 1'b0, "R1", "cnt_valid drops after final word", cnt_valid, 0);
        chk(job_ready == 1'b1, "R10", "job_ready after job", job_ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        job_valid = 1'b0;
        job_addr = '0;
        job_len = '0;
        in_valid = 1'b0;
        in_byte = '0;
        out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(job_ready == 1'b1, "R10", "reset job_ready", job_ready, 1);
        chk(out_valid == 1'b0, "R7", "reset out_valid", out_valid, 0);
        chk(in_ready == 1'b0, "R10", "reset in_ready", in_ready, 0);
        chk(cnt_valid == 1'b0, "R1", "reset cnt_valid", cnt_valid, 0);
        chk(err_zero_len == 1'b0, "R9", "reset error flag", err_zero_len, 0);

        run_job(2, 0, 1, 0);
        for (int g = 0; g < BW; g++) begin
            for (int n = 1; n <= 9; n++) begin
                run_job(g, n, g * 16 + n, (g + n) % 3);
            end
        end
        run_job(0, 16, 70, 0);
        run_job(0, 12, 71, 2);
        run_job(3, 37, 72, 2);
        run_job(1, 0, 73, 1);
        run_job(1, 2, 74, 1);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule